// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. Request lines are captured into a pending-request register, either on a rising transition or as a level. Pending bits that are masked off are discarded. The highest pending level is compared against the levels already in service. When a request outranks everything in service, an interrupt line to the processor is raised.

The processor answers with two acknowledge pulses. The first pulse moves the winning level from pending to in service. The second pulse drives a vector byte, made of a programmed base and the level number, with a one-cycle enable. Decoded command pulses retire in-service levels, either the top one or a named one. Commands can also move the lowest-priority position, so that priority rotates instead of staying fixed. An optional automatic mode retires the level on the second pulse by itself. A poll read can replace the acknowledge pair.

Priority is circular. One level is marked lowest, and the level just above it in wrap-around order is the highest. After reset the lowest is level 7, so level 0 ranks first.

Top module: `irq_prio_core`

## Requirements
- R1: In edge mode (`cfg_level_mode`=0), a 0-to-1 transition on `irq_in[i]` sets pending bit i one clock later, and the bit stays set until it is granted. In level mode, pending bit i copies `irq_in[i]` each clock.
- R2: A pending bit whose `cfg_mask` bit is 1 never raises `int_out` and is never granted.
- R3: `int_out` is 1 the clock after an unmasked pending level outranks every in-service level. It is 0 the clock after a first acknowledge is accepted.
- R4: The first `ack_pulse` sets the in-service bit of the winning level and clears its pending bit.
- R5: The second `ack_pulse` makes `vec_oe` 1 for exactly one clock, with `vec_out` = {`cfg_vec_base`, 3-bit level}.
- R6: While a level is in service, pending levels of equal or lower rank do not raise `int_out`. Higher-ranked levels do.
- R7: `cmd_code` 001 clears the highest-ranked in-service bit. 011 clears the bit named by `cmd_level`. 010 changes nothing.
- R8: `cmd_code` 101 clears the highest-ranked in-service bit and makes that level the lowest. 111 clears bit `cmd_level` and makes that level the lowest.
- R9: `cmd_code` 110 makes `cmd_level` the lowest-priority level and clears no in-service bit.
- R10: With `cfg_auto_eoi`=1, the in-service bit is cleared on the second acknowledge. After `cmd_code` 100 and until `cmd_code` 000, that second acknowledge also makes the serviced level the lowest.
- R11: If no unmasked level wins at the first acknowledge, no in-service bit is set and the second acknowledge returns level 7.
- R12: A `poll_rd` pulse loads `poll_data` with bit 7 = a level wins and bits 2..0 = that level (all zero if none), and grants that level as a first acknowledge would.
- R13: After reset, pending and in-service are zero, `int_out` and `vec_oe` are 0, and level 0 ranks highest with level 7 lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines |
| cfg_level_mode | input | 1 | 1 = level capture, 0 = edge capture |
| cfg_auto_eoi | input | 1 | Retire level on second acknowledge |
| cfg_mask | input | 8 | 1 = level masked |
| cfg_vec_base | input | 5 | Upper vector bits |
| ack_pulse | input | 1 | One-clock acknowledge strobe |
| poll_rd | input | 1 | One-clock poll read strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| cmd_level | input | 3 | Level operand of command |
| int_out | output | 1 | Interrupt to processor |
| vec_out | output | 8 | Vector byte |
| vec_oe | output | 1 | Vector valid, one clock |
| poll_data | output | 8 | Poll result |
| irr_out | output | 8 | Pending-request register |
| isr_out | output | 8 | In-service register |

## Verification
The bench applies a single request first, then two simultaneous requests of different rank. Together these separate correct ranking from simple first-come order. A lower-ranked request arriving while a higher one is in service, and the reverse case, show whether nesting blocks only the levels it should. The rank is moved with set-priority, both rotate-on-retire commands and automatic rotation, and the same pair of requests is then expected to resolve differently. A level request that drops before acknowledge, and polls with and without a pending request, cover the no-winner cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [2:0] {
    OP_AROT_OFF  = 3'b000,
    OP_EOI_TOP   = 3'b001,
    OP_NOP       = 3'b010,
    OP_EOI_NAMED = 3'b011,
    OP_AROT_ON   = 3'b100,
    OP_ROT_TOP   = 3'b101,
    OP_SET_LOW   = 3'b110,
    OP_ROT_NAMED = 3'b111
  } prio_op_e;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] cap;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      if (level_mode) cap[i] = lines[i];
      else            cap[i] = pend_q[i] | (lines[i] & ~prev_q[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= lines[i];
        pend_q[i] <= cap[i] & ~clr[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int LVL_W = 3
) (
  input  logic [(1<<LVL_W)-1:0] vec,
  input  logic [LVL_W-1:0]      low,
  output logic                  found,
  output logic [LVL_W-1:0]      lvl,
  output logic [LVL_W-1:0]      rank
);
  localparam int N = 1 << LVL_W;

  always_comb begin
    logic [LVL_W-1:0] idx;
    found = 1'b0;
    lvl   = '0;
    rank  = '0;
    idx   = '0;
    for (int r = N - 1; r >= 0; r--) begin
      idx = low + LVL_W'(1) + LVL_W'(r);
      if (vec[idx]) begin
        found = 1'b1;
        lvl   = idx;
        rank  = LVL_W'(r);
      end
    end
  end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [(1<<LVL_W)-1:0]    irq_in,
  input  logic                     cfg_level_mode,
  input  logic                     cfg_auto_eoi,
  input  logic [(1<<LVL_W)-1:0]    cfg_mask,
  input  logic [VEC_W-LVL_W-1:0]   cfg_vec_base,
  input  logic                     ack_pulse,
  input  logic                     poll_rd,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_code,
  input  logic [LVL_W-1:0]         cmd_level,
  output logic                     int_out,
  output logic [VEC_W-1:0]         vec_out,
  output logic                     vec_oe,
  output logic [VEC_W-1:0]         poll_data,
  output logic [(1<<LVL_W)-1:0]    irr_out,
  output logic [(1<<LVL_W)-1:0]    isr_out
);
  import irq_prio_pkg::*;

  localparam int N     = 1 << LVL_W;
  localparam int PAD_W = VEC_W - 1 - LVL_W;
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(N - 1);

  logic [N-1:0]     irr_q, isr_q, isr_d;
  logic [N-1:0]     grant_vec, aeoi_clr, cmd_clr;
  logic [LVL_W-1:0] low_q, low_d;
  logic             rot_aeoi_q;
  logic             seq_wait;
  logic [LVL_W-1:0] svc_lvl;
  logic             svc_spur;

  logic             req_found, act_found, win;
  logic [LVL_W-1:0] req_lvl, req_rank, act_lvl, act_rank;
  logic             take_poll, take_ack1, take_ack2, grant, aeoi_hit;
  logic             cmd_low_we;
  logic [LVL_W-1:0] cmd_low_val;

  irq_req_capture #(.N(N)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .level_mode (cfg_level_mode),
    .lines      (irq_in),
    .clr        (grant_vec),
    .pend_q     (irr_q)
  );

  irq_prio_pick #(.LVL_W(LVL_W)) u_pick_req (
    .vec   (irr_q & ~cfg_mask),
    .low   (low_q),
    .found (req_found),
    .lvl   (req_lvl),
    .rank  (req_rank)
  );

  irq_prio_pick #(.LVL_W(LVL_W)) u_pick_act (
    .vec   (isr_q),
    .low   (low_q),
    .found (act_found),
    .lvl   (act_lvl),
    .rank  (act_rank)
  );

  // a pending level wins only if it strictly outranks the top in-service level
  assign win       = req_found && (!act_found || (req_rank < act_rank));
  assign take_poll = poll_rd;
  assign take_ack1 = ack_pulse && !seq_wait && !poll_rd;
  assign take_ack2 = ack_pulse &&  seq_wait && !poll_rd;
  assign grant     = (take_poll || take_ack1) && win;
  assign grant_vec = grant ? (N'(1) << req_lvl) : '0;
  assign aeoi_hit  = take_ack2 && cfg_auto_eoi && !svc_spur;
  assign aeoi_clr  = aeoi_hit ? (N'(1) << svc_lvl) : '0;

  always_comb begin
    cmd_clr     = '0;
    cmd_low_we  = 1'b0;
    cmd_low_val = low_q;
    if (cmd_valid) begin
      unique case (prio_op_e'(cmd_code))
        OP_EOI_TOP:   if (act_found) cmd_clr = N'(1) << act_lvl;
        OP_EOI_NAMED: cmd_clr = N'(1) << cmd_level;
        OP_ROT_TOP: begin
          if (act_found) begin
            cmd_clr     = N'(1) << act_lvl;
            cmd_low_we  = 1'b1;
            cmd_low_val = act_lvl;
          end
        end
        OP_ROT_NAMED: begin
          cmd_clr     = N'(1) << cmd_level;
          cmd_low_we  = 1'b1;
          cmd_low_val = cmd_level;
        end
        OP_SET_LOW: begin
          cmd_low_we  = 1'b1;
          cmd_low_val = cmd_level;
        end
        OP_NOP, OP_AROT_ON, OP_AROT_OFF: ;
        default: ;
      endcase
    end
  end

  always_comb begin
    isr_d = (isr_q & ~(aeoi_clr | cmd_clr)) | grant_vec;
    if (cmd_low_we)                low_d = cmd_low_val;
    else if (aeoi_hit && rot_aeoi_q) low_d = svc_lvl;
    else                           low_d = low_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q      <= '0;
      low_q      <= LVL_MAX;
      rot_aeoi_q <= 1'b0;
      seq_wait   <= 1'b0;
      svc_lvl    <= '0;
      svc_spur   <= 1'b0;
      int_out    <= 1'b0;
      vec_out    <= '0;
      vec_oe     <= 1'b0;
      poll_data  <= '0;
    end else begin
      isr_q   <= isr_d;
      low_q   <= low_d;
      int_out <= win && !seq_wait && !ack_pulse && !poll_rd;
      vec_oe  <= take_ack2;
      if (cmd_valid && cmd_code == OP_AROT_ON)  rot_aeoi_q <= 1'b1;
      if (cmd_valid && cmd_code == OP_AROT_OFF) rot_aeoi_q <= 1'b0;
      if (take_ack1) begin
        seq_wait <= 1'b1;
        svc_lvl  <= win ? req_lvl : LVL_MAX;
        svc_spur <= !win;
      end
      if (take_ack2) begin
        seq_wait <= 1'b0;
        vec_out  <= {cfg_vec_base, svc_lvl};
      end
      if (take_poll)
        poll_data <= {win, {PAD_W{1'b0}}, (win ? req_lvl : {LVL_W{1'b0}})};
    end
  end

  assign irr_out = irr_q;
  assign isr_out = isr_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [(1<<LVL_W)-1:0]  cfg_mask,
  input logic [VEC_W-LVL_W-1:0] cfg_vec_base,
  input logic                   ack_pulse,
  input logic                   poll_rd,
  input logic                   seq_wait,
  input logic                   int_out,
  input logic [VEC_W-1:0]       vec_out,
  input logic                   vec_oe,
  input logic [(1<<LVL_W)-1:0]  irr_out,
  input logic [(1<<LVL_W)-1:0]  isr_out
);
  AST_ONE_NEW_SERVICE: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_out & ~$past(isr_out)) <= 1); // R4
  AST_MASKED_NOT_GRANTED: assert property (@(posedge clk) disable iff (rst)
    ((isr_out & ~$past(isr_out)) & $past(cfg_mask)) == '0); // R2
  AST_INT_DROPS_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !seq_wait && !poll_rd) |=> !int_out); // R3
  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr_out & ~cfg_mask) != '0)); // R3
  AST_VEC_BASE_BITS: assert property (@(posedge clk) disable iff (rst)
    vec_oe |-> (vec_out[VEC_W-1:LVL_W] == $past(cfg_vec_base))); // R5
  AST_VEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vec_oe |=> !vec_oe); // R5
endmodule

bind irq_prio_core irq_prio_core_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_mask     (cfg_mask),
  .cfg_vec_base (cfg_vec_base),
  .ack_pulse    (ack_pulse),
  .poll_rd      (poll_rd),
  .seq_wait     (seq_wait),
  .int_out      (int_out),
  .vec_out      (vec_out),
  .vec_oe       (vec_oe),
  .irr_out      (irr_out),
  .isr_out      (isr_out)
);

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       cfg_level_mode = 1'b0, cfg_auto_eoi = 1'b0;
  logic [7:0] cfg_mask = '0;
  logic [4:0] cfg_vec_base = 5'h08;
  logic       ack_pulse = 1'b0, poll_rd = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0, cmd_level = '0;
  logic       int_out, vec_oe;
  logic [7:0] vec_out, poll_data, irr_out, isr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_core u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_level_mode(cfg_level_mode),
    .cfg_auto_eoi(cfg_auto_eoi), .cfg_mask(cfg_mask), .cfg_vec_base(cfg_vec_base),
    .ack_pulse(ack_pulse), .poll_rd(poll_rd), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_level(cmd_level), .int_out(int_out),
    .vec_out(vec_out), .vec_oe(vec_oe), .poll_data(poll_data),
    .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_irr, m_isr, m_prev, m_vec, m_poll;
  int         m_low, m_lvl;
  bit         m_rot, m_wait, m_spur, m_int, m_oe;

  function automatic int best(logic [7:0] v, int low);
    for (int r = 0; r < N; r++) begin
      int idx = (low + 1 + r) % N;
      if (v[idx]) return idx;
    end
    return -1;
  endfunction

  function automatic int rank_of(int l, int low);
    return (l - low - 1 + 2 * N) % N;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_irr = '0; m_isr = '0; m_prev = '0; m_vec = '0; m_poll = '0;
      m_low = 7; m_lvl = 0; m_rot = 0; m_wait = 0; m_spur = 0; m_int = 0; m_oe = 0;
    end else begin
      int pl, il, nlow;
      bit win;
      logic [7:0] cap, irr_clr, isr_set, isr_clr;
      pl = best(m_irr & ~cfg_mask, m_low);
      il = best(m_isr, m_low);
      win = (pl >= 0) && (il < 0 || rank_of(pl, m_low) < rank_of(il, m_low));
      cap = cfg_level_mode ? irq_in : (m_irr | (irq_in & ~m_prev));
      m_prev = irq_in;
      irr_clr = '0; isr_set = '0; isr_clr = '0; nlow = m_low;
      m_int = win && !m_wait && !ack_pulse && !poll_rd;
      m_oe = 0;
      if (poll_rd) begin
        m_poll = win ? (8'h80 | 8'(pl)) : 8'h00;
        if (win) begin isr_set[pl] = 1; irr_clr[pl] = 1; end
      end else if (ack_pulse) begin
        if (!m_wait) begin
          if (win) begin isr_set[pl] = 1; irr_clr[pl] = 1; m_lvl = pl; m_spur = 0; end
          else begin m_lvl = 7; m_spur = 1; end
          m_wait = 1;
        end else begin
          m_vec = {cfg_vec_base, 3'(m_lvl)};
          m_oe = 1;
          if (cfg_auto_eoi && !m_spur) begin
            isr_clr[m_lvl] = 1;
            if (m_rot) nlow = m_lvl;
          end
          m_wait = 0;
        end
      end
      if (cmd_valid) begin
        case (cmd_code)
          3'b001: if (il >= 0) isr_clr[il] = 1;
          3'b011: isr_clr[cmd_level] = 1;
          3'b101: if (il >= 0) begin isr_clr[il] = 1; nlow = il; end
          3'b111: begin isr_clr[cmd_level] = 1; nlow = int'(cmd_level); end
          3'b110: nlow = int'(cmd_level);
          3'b100: m_rot = 1;
          3'b000: m_rot = 0;
          default: ;
        endcase
      end
      m_isr = (m_isr & ~isr_clr) | isr_set;
      m_irr = cap & ~irr_clr;
      m_low = nlow;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 model irr", irr_out, m_irr);
      chk("R4 model isr", isr_out, m_isr);
      chk("R3 model int", int_out, m_int);
      chk("R5 model vec_oe", vec_oe, m_oe);
      if (m_oe) chk("R5 model vec", vec_out, m_vec);
      chk("R12 model poll", poll_data, m_poll);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack_pair(string tag, logic [7:0] exp_vec);
    ack_pulse = 1; tick(); ack_pulse = 0;
    chk({tag, " int low after first ack"}, int_out, 1'b0);
    ack_pulse = 1; tick(); ack_pulse = 0;
    chk({tag, " vec_oe"}, vec_oe, 1'b1);
    chk({tag, " vector"}, vec_out, exp_vec);
    tick();
    chk({tag, " vec_oe single"}, vec_oe, 1'b0);
  endtask

  task automatic cmd(logic [2:0] code, logic [2:0] lvl);
    cmd_valid = 1; cmd_code = code; cmd_level = lvl; tick(); cmd_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    tick();
    chk("R13 reset irr", irr_out, 8'h00);
    chk("R13 reset isr", isr_out, 8'h00);
    chk("R13 reset int", int_out, 1'b0);
    chk("R13 reset vec_oe", vec_oe, 1'b0);

    // default ranking: 0 over 7
    irq_in = 8'h81; tick();
    chk("R1 edge capture", irr_out, 8'h81);
    tick();
    chk("R3 int raised", int_out, 1'b1);
    ack_pair("R13 level0 first", 8'h40);
    chk("R4 isr set", isr_out, 8'h01);
    chk("R4 irr cleared", irr_out, 8'h80);
    chk("R6 lower blocked", int_out, 1'b0);
    cmd(3'b001, 3'd0); tick();
    chk("R7 nonspecific clears", isr_out, 8'h00);
    ack_pair("R13 level7 next", 8'h47);
    cmd(3'b011, 3'd7);
    irq_in = 8'h00; tick();

    // nesting
    irq_in = 8'h08; tick(); tick();
    ack_pair("R5 level3", 8'h43);
    irq_in = 8'h28; tick(); tick();
    chk("R6 level5 blocked by 3", int_out, 1'b0);
    irq_in = 8'h2A; tick(); tick();
    chk("R6 level1 preempts 3", int_out, 1'b1);
    ack_pair("R6 level1", 8'h41);
    chk("R6 nested isr", isr_out, 8'h0A);
    cmd(3'b001, 3'd0);
    chk("R7 top cleared", isr_out, 8'h08);
    cmd(3'b010, 3'd3);
    chk("R7 nop keeps isr", isr_out, 8'h08);
    cmd(3'b011, 3'd3);
    chk("R7 named cleared", isr_out, 8'h00);
    tick();
    ack_pair("R6 level5 after retire", 8'h45);
    cmd(3'b011, 3'd5);
    irq_in = 8'h00; tick();

    // mask
    cfg_mask = 8'h04; irq_in = 8'h04; tick(); tick();
    chk("R2 masked no int", int_out, 1'b0);
    chk("R2 masked still pending", irr_out, 8'h04);
    cfg_mask = 8'h00; tick(); tick();
    chk("R2 unmasked int", int_out, 1'b1);
    ack_pair("R2 level2", 8'h42);
    cmd(3'b011, 3'd2);
    irq_in = 8'h00; tick();

    // set priority and rotation
    cmd(3'b110, 3'd4);
    chk("R9 isr untouched", isr_out, 8'h00);
    irq_in = 8'h44; tick(); tick();
    ack_pair("R9 level6 outranks 2", 8'h46);
    cmd(3'b111, 3'd6);
    chk("R8 named rotate clears", isr_out, 8'h00);
    tick();
    ack_pair("R8 level2", 8'h42);
    cmd(3'b101, 3'd0);
    chk("R8 top rotate clears", isr_out, 8'h00);
    irq_in = 8'h00; tick();
    irq_in = 8'h0A; tick(); tick();
    ack_pair("R8 level3 over 1", 8'h43);
    cmd(3'b001, 3'd0); tick();
    ack_pair("R8 level1 follows", 8'h41);
    cmd(3'b001, 3'd0);
    irq_in = 8'h00; tick();

    // automatic retire and rotation
    cfg_auto_eoi = 1;
    cmd(3'b100, 3'd0);
    irq_in = 8'h01; tick(); tick();
    ack_pair("R10 level0", 8'h40);
    chk("R10 auto retire", isr_out, 8'h00);
    irq_in = 8'h00; tick();
    irq_in = 8'h03; tick(); tick();
    ack_pair("R10 rotated level1 first", 8'h41);
    ack_pair("R10 level0 second", 8'h40);
    cmd(3'b000, 3'd0);
    cfg_auto_eoi = 0;
    irq_in = 8'h00; tick();

    // level mode, vanished request
    cfg_level_mode = 1;
    irq_in = 8'h10; tick(); tick();
    chk("R3 level int", int_out, 1'b1);
    irq_in = 8'h00; tick();
    chk("R1 level follows line", irr_out, 8'h00);
    ack_pair("R11 no winner", 8'h47);
    chk("R11 no service", isr_out, 8'h00);

    // poll
    irq_in = 8'h40; tick(); tick();
    poll_rd = 1; tick(); poll_rd = 0;
    chk("R12 poll data", poll_data, 8'h86);
    chk("R12 poll grants", isr_out, 8'h40);
    irq_in = 8'h00; tick();
    cmd(3'b011, 3'd6);
    poll_rd = 1; tick(); poll_rd = 0;
    chk("R12 poll empty", poll_data, 8'h00);
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule